// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable, cycle-level model of a synchronous static RAM. Every word holds four 9-bit byte lanes. The address, the control inputs and the write data are all sampled on the rising clock edge. Read data leaves through an output register, so each read reaches the output one clock after its address was registered. A cycle can be started by either of two active-low address strobes, and the two are gated differently. One strobe belongs to the processor side and is qualified by the chip enable. The other belongs to the cache-controller side and is not. After that first cycle, an access continues as a two-bit burst that wraps within four words. The burst can step to the next address or hold its current address, and the step order is either linear or interleaved.

Write control has two levels. A global write stores the whole word. Below it, a byte-write enable admits per-lane write bits. Data in and data out are separate buses. The model does not drive a tristate pad. Instead, a drive flag reports when a real bidirectional bus would carry read data. An output-enable input masks that flag asynchronously. A sleep input freezes every clocked element and keeps the memory contents.

Top module: `ssram_pipe_burst`

## Requirements
- R1: A new address is loaded on a rising edge when `strb_ctl_n` is low, or when `strb_cpu_n` is low while `ce_n` is low. With `ce_n` high, `strb_cpu_n` has no effect, and a running burst continues as if no strobe were present.
- R2: The chip counts as selected only when `ce_n` is low, `sel_hi` is high and `sel_lo_n` is low. A strobed cycle that is not selected is a deselect: it ends the burst, and `dout_en` is low after the following rising edge.
- R3: The word at the address registered on edge N appears on `dout`, with `dout_en` high, after edge N+1. A continuing burst read delivers one word on every later edge.
- R4: `gw_n` low writes all four lanes from `din`, whatever the values of `bwen_n` and `bw_n`.
- R5: With `gw_n` high and `bwen_n` low, each low bit `bw_n[i]` writes lane i, and any number of lanes may be written together. With `gw_n` and `bwen_n` both high, the cycle is a read and nothing is written.
- R6: Lane i occupies bits [9i+8:9i] of `din` and `dout`. Bit 9i+8 of each lane is its parity bit.
- R7: On a write cycle, `dout_en` is low after that cycle's edge.
- R8: On a cycle with no strobe during an active burst, `adv_n` low steps the burst count and `adv_n` high holds it. The two low address bits are start+count mod 4 when `interleave` is 0, and start XOR count when it is 1. After four steps the sequence returns to the start address.
- R9: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge.
- R10: While `sleep` is high, no register and no memory word changes, so `dout` holds its value.
- R11: The first cycle of an access started by `strb_cpu_n` is always a read, even with write controls active. An access started by `strb_ctl_n` alone writes on its first cycle when a write is requested.
- R12: Synchronous active-high `rst` clears the burst and the read pipeline, so `dout_en` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | High freezes all clocked state |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low, qualified by `ce_n` |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst step, active low |
| gw_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write bits, active low, bit i for lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | High when the data bus would be driven |

## Verification
On every cycle, the assertions check the timing rules that the port pins alone decide: a deselect drops the drive flag two edges later, a write edge blanks it at once, a selected read produces data after one extra edge even when write controls came with a processor strobe, and sleep holds `dout`. Burst order, lane merging, the priority of global write over byte writes, the processor strobe being ignored while `ce_n` is high, and memory retention across sleep all depend on memory contents. Only the bench scenarios can show these, by writing patterns and reading them back word by word.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

    localparam int LANE_W  = 9;
    localparam int LANES   = 4;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e  kind;
        logic       load;
        logic       step;
        lane_mask_t lanes;
    } cyc_cmd_t;

    // Low burst bits for a start offset and a step count.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] count,
        input logic               ilv
    );
        return ilv ? (start ^ count) : (start + count);
    endfunction

endpackage

// File: rtl/ssram_cmd_decode.sv
module ssram_cmd_decode
    import ssram_pkg::*;
(
    input  logic       strb_cpu_n,
    input  logic       strb_ctl_n,
    input  logic       ce_n,
    input  logic       sel_hi,
    input  logic       sel_lo_n,
    input  logic       adv_n,
    input  logic       gw_n,
    input  logic       bwen_n,
    input  logic [3:0] bw_n,
    input  logic       active,
    output cyc_cmd_t   cmd
);

    logic       cpu_go;
    logic       ctl_go;
    logic       chip_on;
    lane_mask_t req_lanes;

    assign cpu_go  = !strb_cpu_n && !ce_n;
    assign ctl_go  = !strb_ctl_n;
    assign chip_on = !ce_n && sel_hi && !sel_lo_n;

    // Global write outranks the gated per-lane bits.
    always_comb begin
        if (!gw_n)
            req_lanes = '1;
        else if (!bwen_n)
            req_lanes = ~bw_n;
        else
            req_lanes = '0;
    end

    always_comb begin
        cmd       = '0;
        cmd.kind  = CYC_IDLE;
        if (cpu_go || ctl_go) begin
            cmd.load = 1'b1;
            if (!chip_on) begin
                cmd.kind = CYC_DESEL;
            end else if (cpu_go) begin
                cmd.kind = CYC_READ;
            end else if (|req_lanes) begin
                cmd.kind  = CYC_WRITE;
                cmd.lanes = req_lanes;
            end else begin
                cmd.kind = CYC_READ;
            end
        end else if (active) begin
            cmd.step = !adv_n;
            if (|req_lanes) begin
                cmd.kind  = CYC_WRITE;
                cmd.lanes = req_lanes;
            end else begin
                cmd.kind = CYC_READ;
            end
        end
    end

endmodule

// File: rtl/ssram_burst_addr.sv
module ssram_burst_addr
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  cyc_cmd_t          cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    base_hi_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] count_q;
    logic [BURST_W-1:0] count_nx;
    logic               active_q;

    assign count_nx = count_q + BURST_W'(cmd.step);
    assign active   = active_q;

    always_comb begin
        if (cmd.load)
            cur_addr = addr_in;
        else
            cur_addr = {base_hi_q, burst_low(start_q, count_nx, ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi_q <= '0;
            start_q   <= '0;
            count_q   <= '0;
            active_q  <= 1'b0;
        end else if (en) begin
            if (cmd.load) begin
                active_q  <= (cmd.kind != CYC_DESEL);
                base_hi_q <= addr_in[ADDR_W-1:BURST_W];
                start_q   <= addr_in[BURST_W-1:0];
                count_q   <= '0;
            end else if (active_q) begin
                count_q <= count_nx;
            end
        end
    end

endmodule

// File: rtl/ssram_array.sv
module ssram_array
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  lane_mask_t        wr_lanes,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  word_t             wr_data,
    output word_t             rd_data,
    output logic              rd_pend
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] rd_addr_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (en && wr_lanes[g])
                cells[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q <= '0;
            rd_pend   <= 1'b0;
        end else if (en) begin
            rd_addr_q <= acc_addr;
            rd_pend   <= rd_req;
        end
    end

endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage
    import ssram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  rd_pend,
    input  logic  wr_now,
    input  word_t rd_data,
    output word_t q,
    output logic  q_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q_vld <= 1'b0;
        end else if (en) begin
            q     <= rd_data;
            q_vld <= rd_pend && !wr_now;
        end
    end

endmodule

// File: rtl/ssram_pipe_burst.sv
module ssram_pipe_burst
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              ce_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwen_n,
    input  logic [3:0]        bw_n,
    input  logic              oe_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       din,
    output logic [35:0]       dout,
    output logic              dout_en
);

    logic              en;
    cyc_cmd_t          cmd;
    logic              active;
    logic [ADDR_W-1:0] cur_addr;
    lane_mask_t        wr_lanes;
    logic              wr_now;
    logic              rd_req;
    word_t             rd_data;
    logic              rd_pend;
    word_t             rd_word;
    logic              rd_vld;

    assign en       = !sleep;
    assign wr_now   = (cmd.kind == CYC_WRITE);
    assign rd_req   = (cmd.kind == CYC_READ);
    assign wr_lanes = wr_now ? cmd.lanes : '0;

    ssram_cmd_decode u_dec (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .ce_n       (ce_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .adv_n      (adv_n),
        .gw_n       (gw_n),
        .bwen_n     (bwen_n),
        .bw_n       (bw_n),
        .active     (active),
        .cmd        (cmd)
    );

    ssram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cmd      (cmd),
        .addr_in  (addr),
        .ilv      (interleave),
        .cur_addr (cur_addr),
        .active   (active)
    );

    ssram_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wr_lanes (wr_lanes),
        .rd_req   (rd_req),
        .acc_addr (cur_addr),
        .wr_data  (din),
        .rd_data  (rd_data),
        .rd_pend  (rd_pend)
    );

    ssram_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .rd_pend (rd_pend),
        .wr_now  (wr_now),
        .rd_data (rd_data),
        .q       (rd_word),
        .q_vld   (rd_vld)
    );

    assign dout    = rd_word;
    assign dout_en = rd_vld && !oe_n;

endmodule

// File: rtl/ssram_chk.sv
module ssram_chk (
    input logic        clk,
    input logic        rst,
    input logic        sleep,
    input logic        strb_cpu_n,
    input logic        strb_ctl_n,
    input logic        ce_n,
    input logic        sel_hi,
    input logic        sel_lo_n,
    input logic        gw_n,
    input logic        bwen_n,
    input logic        oe_n,
    input logic [35:0] dout,
    input logic        dout_en
);

    logic cpu_go;
    logic ctl_go;
    logic chip_on;

    assign cpu_go  = !strb_cpu_n && !ce_n;
    assign ctl_go  = !strb_ctl_n;
    assign chip_on = !ce_n && sel_hi && !sel_lo_n;

    // R2: single-cycle deselect
    p_desel_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (!sleep && (cpu_go || ctl_go) && !chip_on) ##1 !sleep |=> !dout_en);

    // R3: one pipeline stage between address and data
    p_read_lat_r3: assert property (@(posedge clk) disable iff (rst)
        (!sleep && cpu_go && chip_on) ##1 (!sleep && gw_n && bwen_n)
        |=> (dout_en || oe_n));

    // R7: a write edge blanks the bus flag
    p_write_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ctl_go && !cpu_go && chip_on && !gw_n) |=> !dout_en);

    // R10: sleep freezes the output register
    p_sleep_hold_r10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(dout));

    // R11: processor-started access reads on its first cycle
    p_cpu_first_read_r11: assert property (@(posedge clk) disable iff (rst)
        (!sleep && cpu_go && chip_on && !gw_n) ##1 (!sleep && gw_n && bwen_n)
        |=> (dout_en || oe_n));

endmodule

bind ssram_pipe_burst ssram_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep      (sleep),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .ce_n       (ce_n),
    .sel_hi     (sel_hi),
    .sel_lo_n   (sel_lo_n),
    .gw_n       (gw_n),
    .bwen_n     (bwen_n),
    .oe_n       (oe_n),
    .dout       (dout),
    .dout_en    (dout_en)
);

// File: tb/tb_ssram_pipe_burst.sv
`timescale 1ns/1ps
module tb_ssram_pipe_burst;

    logic        clk = 1'b0;
    logic        rst, sleep, strb_cpu_n, strb_ctl_n, ce_n, sel_hi, sel_lo_n;
    logic        adv_n, gw_n, bwen_n, oe_n, interleave;
    logic [3:0]  bw_n;
    logic [5:0]  addr;
    logic [35:0] din;
    logic [35:0] dout;
    logic        dout_en;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R12";

    always #2.5 clk = ~clk;

    ssram_pipe_burst #(.ADDR_W(6)) dut (
        .clk(clk), .rst(rst), .sleep(sleep), .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n), .ce_n(ce_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .adv_n(adv_n), .gw_n(gw_n), .bwen_n(bwen_n), .bw_n(bw_n), .oe_n(oe_n),
        .interleave(interleave), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // ---------------- behavioural reference ----------------
    logic [35:0] mmem [int];
    bit          m_act, m_pend, m_vld;
    int          m_base, m_k, m_paddr;
    logic [35:0] m_out;
    bit          x_cpu, x_ctl, x_on, x_rd, x_wr;
    logic [3:0]  x_mask;
    int          x_a, x_lo;

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] m);
        logic [35:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_pend = 0; m_vld = 0; m_k = 0;
        end else if (!sleep) begin
            x_cpu  = !strb_cpu_n && !ce_n;
            x_ctl  = !strb_ctl_n;
            x_on   = !ce_n && sel_hi && !sel_lo_n;
            x_mask = !gw_n ? 4'hF : (!bwen_n ? ~bw_n : 4'h0);
            x_rd = 0; x_wr = 0; x_a = 0;
            if (x_cpu || x_ctl) begin
                if (!x_on) m_act = 0;
                else begin
                    m_act = 1; m_base = int'(addr); m_k = 0; x_a = int'(addr);
                    if (x_cpu || x_mask == 0) x_rd = 1; else x_wr = 1;
                end
            end else if (m_act) begin
                if (!adv_n) m_k = (m_k + 1) % 4;
                x_lo = interleave ? ((m_base % 4) ^ m_k) : ((m_base % 4 + m_k) % 4);
                x_a  = (m_base / 4) * 4 + x_lo;
                if (x_mask != 0) x_wr = 1; else x_rd = 1;
            end
            m_vld = m_pend && !x_wr;
            if (m_pend) m_out = mmem.exists(m_paddr) ? mmem[m_paddr] : 36'h0;
            m_pend  = x_rd;
            m_paddr = x_a;
            if (x_wr)
                mmem[x_a] = merge(mmem.exists(x_a) ? mmem[x_a] : 36'h0, din, x_mask);
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_req, " flag"}, 36'(dout_en), 36'(m_vld && !oe_n));
            if (m_vld && !oe_n) check({cur_req, " data"}, dout, m_out);
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        strb_cpu_n = 1; strb_ctl_n = 1; ce_n = 0; sel_hi = 1; sel_lo_n = 0;
        adv_n = 1; gw_n = 1; bwen_n = 1; bw_n = 4'hF;
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr_ctl(input logic [5:0] a, input logic [35:0] d);
        idle(); strb_ctl_n = 0; addr = a; gw_n = 0; din = d; tick(); idle();
    endtask

    task automatic rd_cpu(input logic [5:0] a);
        idle(); strb_cpu_n = 0; addr = a; tick(); idle();
    endtask

    task automatic desel();
        idle(); strb_ctl_n = 0; sel_hi = 0; tick(); idle();
    endtask

    task automatic read_word(input string req, input logic [5:0] a, input logic [35:0] exp);
        rd_cpu(a); tick();
        check(req, dout, exp);
        check(req, 36'(dout_en), 36'h1);
        desel();
    endtask

    logic [35:0] w0, wb [4], v8;
    int          lin [4], ilv [4];

    initial begin
        idle(); rst = 1; sleep = 0; oe_n = 0; interleave = 0; addr = 0; din = 0;
        for (int k = 0; k < 4; k++) wb[k] = {4'(k + 1), 32'hC0DE_0000 + 32'(k)};
        lin = '{17, 18, 19, 16};
        ilv = '{17, 16, 19, 18};
        w0  = 36'h1_2345_6789;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        tick();
        check("R12 reset flag", 36'(dout_en), 36'h0);

        // R4 global write, R6 lane layout, R5 byte writes
        cur_req = "R4";
        wr_ctl(8, w0); desel();
        read_word("R4 full word", 8, w0);
        cur_req = "R5";
        idle(); strb_ctl_n = 0; addr = 8; bwen_n = 0; bw_n = 4'b1010; din = '1; tick(); idle();
        desel();
        v8 = merge(w0, '1, 4'b0101);
        read_word("R6 lanes 0 and 2 only", 8, v8);
        idle(); strb_ctl_n = 0; addr = 8; bw_n = 4'b0000; din = '0; tick(); idle();
        desel();
        read_word("R5 gated off no write", 8, v8);
        cur_req = "R4";
        idle(); strb_ctl_n = 0; addr = 8; gw_n = 0; bwen_n = 0; bw_n = 4'b1110; din = '0;
        tick(); idle(); desel();
        read_word("R4 global over byte", 8, 36'h0);

        // R11 processor strobe reads even with write controls
        cur_req = "R11";
        idle(); strb_cpu_n = 0; addr = 8; gw_n = 0; din = '1; tick(); idle();
        tick();
        check("R11 first cycle read", 36'(dout_en), 36'h1);
        desel();
        read_word("R11 word unchanged", 8, 36'h0);

        // R8 burst write, linear from 17
        cur_req = "R8";
        wr_ctl(17, wb[0]);
        for (int k = 1; k < 4; k++) begin
            idle(); adv_n = 0; gw_n = 0; din = wb[k]; tick();
        end
        idle(); desel();
        interleave = 0;
        rd_cpu(17);
        for (int k = 0; k < 4; k++) begin
            adv_n = (k < 3) ? 1'b0 : 1'b1; tick();
            check("R8 linear order", dout, wb[lin[k] - 16 == 1 ? 0 : (lin[k] == 18 ? 1 : (lin[k] == 19 ? 2 : 3))]);
        end
        idle(); desel();
        interleave = 1;
        rd_cpu(17);
        for (int k = 0; k < 4; k++) begin
            adv_n = (k < 3) ? 1'b0 : 1'b1; tick();
            check("R8 interleaved order", dout, wb[(ilv[k] - 16 + 3) % 4]);
        end
        idle(); desel();
        interleave = 0;
        rd_cpu(17);
        adv_n = 1; tick(); check("R8 suspend a", dout, wb[0]);
        adv_n = 0; tick(); check("R8 suspend b", dout, wb[0]);
        adv_n = 1; tick(); check("R8 step after hold", dout, wb[1]);
        tick();            check("R8 hold again", dout, wb[1]);
        idle(); desel();

        // R3 latency and back-to-back burst words
        cur_req = "R3";
        rd_cpu(16);
        check("R3 not yet valid", 36'(dout_en), 36'h0);
        adv_n = 0; tick(); check("R3 first word", dout, wb[3]);
        tick();            check("R3 next word", dout, wb[0]);
        idle(); desel();

        // R1 processor strobe ignored with ce_n high
        cur_req = "R1";
        rd_cpu(17);
        ce_n = 1; strb_cpu_n = 0; addr = 8; adv_n = 0; tick();
        idle(); tick();
        check("R1 burst continued", dout, wb[1]);
        desel();

        // R2 deselect variants
        cur_req = "R2";
        rd_cpu(16);
        idle(); strb_ctl_n = 0; sel_hi = 0; tick();
        check("R2 last read still valid", 36'(dout_en), 36'h1);
        idle(); tick();
        check("R2 flag low after deselect", 36'(dout_en), 36'h0);
        rd_cpu(16);
        idle(); strb_cpu_n = 0; sel_lo_n = 1; tick();
        idle(); adv_n = 0; tick();
        check("R2 cpu deselect", 36'(dout_en), 36'h0);
        tick();
        check("R2 stays idle", 36'(dout_en), 36'h0);

        // R7 write blanks output
        cur_req = "R7";
        rd_cpu(16);
        adv_n = 0; gw_n = 0; din = wb[0]; tick();
        check("R7 write blanks flag", 36'(dout_en), 36'h0);
        idle(); desel();

        // R9 asynchronous output enable
        cur_req = "R9";
        rd_cpu(16); tick();
        check("R9 enabled", 36'(dout_en), 36'h1);
        oe_n = 1; #0.5;
        check("R9 oe high off", 36'(dout_en), 36'h0);
        oe_n = 0; #0.5;
        check("R9 oe low on", 36'(dout_en), 36'h1);
        desel();

        // R10 sleep freezes state
        cur_req = "R10";
        rd_cpu(16); tick();
        sleep = 1; strb_ctl_n = 0; addr = 8; gw_n = 0; adv_n = 0; din = '1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R10 dout frozen", dout, wb[3]);
            check("R10 flag frozen", 36'(dout_en), 36'h1);
        end
        idle(); sleep = 0;
        desel();
        read_word("R10 memory kept", 8, 36'h0);
        read_word("R10 burst word kept", 16, wb[3]);

        tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule